// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block steers an incoming byte stream into buffers described by a list of four-word receive descriptors in memory. It starts at the list base address. For each descriptor it reads the status, control and two address words. If the descriptor belongs to the hardware, the block packs frame bytes into 32-bit words and writes them into buffer 1, then into buffer 2. When it closes a descriptor it writes a status word back and steps to the next descriptor, which is the list base, the chained link, or the following slot in memory.

The control word in descriptor word 1 sets the layout:

| Bits | Meaning |
|---|---|
| [12:0] | Buffer 1 size in bytes |
| [28:16] | Buffer 2 size in bytes |
| 14 | Chained mode |
| 15 | Wrap to the list base |
| 31 | Suppress the interrupt for a frame that ends in this descriptor |

Word 2 holds the buffer 1 address. Word 3 holds the buffer 2 address or, in chained mode, the next descriptor address.

The status word (word 0) has these fields:

| Bits | Meaning |
|---|---|
| 31 | Hardware ownership |
| [29:16] | Frame length |
| 9 | First descriptor of the frame |
| 8 | Last descriptor of the frame |
| 1 | CRC error |

The controller is a single state machine with these states:

- S_INIT loads the base address.
- S_FETCH issues one descriptor word read.
- S_LATCH captures the read word.
- S_STALL waits for a poll pulse on a software-owned descriptor.
- S_PICK chooses the first usable buffer.
- S_FILL accepts bytes.
- S_WRDATA writes a packed data word.
- S_WBACK writes the status word.
- S_NEXT moves to the next descriptor.

Its transitions are:

- S_INIT to S_FETCH.
- S_FETCH to S_LATCH.
- S_LATCH back to S_FETCH for words 1 to 3.
- S_LATCH to S_STALL when the ownership bit is clear.
- S_LATCH to S_PICK after word 3.
- S_STALL to S_FETCH on poll.
- S_PICK to S_FILL, or to S_NEXT when no buffer is usable.
- S_FILL to S_WRDATA when a word is full or the frame ends.
- S_WRDATA to S_FILL, or to S_WBACK when the frame ended or no buffer space is left.
- S_WBACK to S_NEXT.
- S_NEXT to S_FETCH.

Top module: `rx_desc_walker`

## Requirements
- R1: Descriptor fetch and ownership.
  - The walker reads the four words at the current descriptor address in order, at byte offsets 0, 4, 8 and 12.
  - If bit 31 of word 0 is clear, it stops and raises `buf_unavail`. It makes no memory access until a `poll` pulse, then it reads the descriptor again.
- R2: Byte packing.
  - Frame bytes are packed little-endian: byte k of a word goes to bits [8k+7:8k].
  - Each word is written at the buffer address plus the running byte offset.
  - Buffer 1 fills first, then buffer 2. A final partial word carries zeros in its unused lanes.
- R3: Zero-size buffers.
  - A buffer 1 size of zero skips buffer 1.
  - A descriptor with no usable buffer is passed over with no write-back.
- R4: Chained mode (bit 14). Word 3 is the next descriptor address, and buffer 2 is never written, whatever its size field holds.
- R5: Wrap (bit 15). The next descriptor address is `ring_base`. This takes priority over chained mode.
- R6: Sequential stepping. With neither bit 15 nor bit 14 set, the next descriptor address is the current address plus 16.
- R7: Status write-back.
  - The written status always has bit 31 clear.
  - Bit 9 is set on the first descriptor of a frame.
  - On the last descriptor only, bit 8 is set, bits [29:16] hold the frame length, and bit 1 holds the CRC error flag.
- R8: Interrupt.
  - `rx_irq` pulses for one cycle, the cycle after a write-back with bit 8 set.
  - It does not pulse when control bit 31 of that descriptor is set.
- R9: Size error. `cfg_err` rises after the control word is read if the buffer 1 size, or the buffer 2 size when chained mode is off, is not a multiple of 4. It clears when the walker moves to the next descriptor.
- R10: Reset state.
  - While in reset, `mem_req`, `rx_ready`, `rx_irq`, `buf_unavail` and `cfg_err` are low.
  - After reset the first descriptor is read at `ring_base`.
- R11: Frame end. The end of a frame always closes the current descriptor, so the next frame starts in a fresh descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW | Byte address of the first descriptor |
| poll | input | 1 | Poll pulse that restarts a stalled walker |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_crc_err | input | 1 | CRC error flag, sampled with the last byte |
| rx_ready | output | 1 | Walker accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_irq | output | 1 | Receive interrupt pulse |
| buf_unavail | output | 1 | Stalled on a software-owned descriptor |
| cfg_err | output | 1 | Current descriptor has a buffer size that is not a multiple of 4 |

## Verification
The assertions assume the following about the environment:

- Memory returns read data exactly one cycle after a read request.
- `poll` is pulsed only while the walker is stalled, or is harmless otherwise.
- Buffer sizes are multiples of 4 except where `cfg_err` is the subject of the check.

The bench keeps within these limits:

- Its memory model answers every read on the next edge.
- It draws random sizes only from multiples of 4.
- It touches descriptor memory only while the walker is held in reset or stalled.
- It sends a random frame only after its own model confirms that the frame fits in the remaining hardware-owned descriptors. This keeps the walker from wrapping onto a descriptor that software owns partway through a frame.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    localparam int SZ_W      = 13;
    localparam int LEN_W     = 14;
    localparam int OWN_BIT   = 31;
    localparam int FIRST_BIT = 9;
    localparam int LAST_BIT  = 8;
    localparam int CRC_BIT   = 1;
    localparam int LEN_LSB   = 16;

    typedef enum logic [3:0] {
        S_INIT, S_FETCH, S_LATCH, S_STALL, S_PICK,
        S_FILL, S_WRDATA, S_WBACK, S_NEXT
    } rxw_state_t;

    typedef struct packed {
        logic            sup;
        logic            eor;
        logic            chain;
        logic [SZ_W-1:0] s2;
        logic [SZ_W-1:0] s1;
    } rxw_ctrl_t;
endpackage

// File: rtl/rxw_buf_sel.sv
module rxw_buf_sel
    import rxw_pkg::*;
(
    input  logic [SZ_W-1:0] s1,
    input  logic [SZ_W-1:0] s2,
    input  logic            chain,
    input  logic [1:0]      start,
    output logic            found,
    output logic            sel
);
    logic use1, use2;

    assign use1 = (s1 != '0);
    assign use2 = !chain && (s2 != '0);

    always_comb begin
        found = 1'b0;
        sel   = 1'b0;
        if (start == 2'd0 && use1) begin
            found = 1'b1;
        end else if (start <= 2'd1 && use2) begin
            found = 1'b1;
            sel   = 1'b1;
        end
    end
endmodule

// File: rtl/rxw_next_addr.sv
module rxw_next_addr #(
    parameter int AW     = 32,
    parameter int STRIDE = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] link,
    input  logic          eor,
    input  logic          chain,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (eor)        nxt = base;
        else if (chain) nxt = link;
        else            nxt = cur + AW'(STRIDE);
    end
endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rxw_pkg::*;
#(
    parameter int AW     = 32,
    parameter int STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          poll,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_crc_err,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          rx_irq,
    output logic          buf_unavail,
    output logic          cfg_err
);
    rxw_state_t       st, st_nx;
    logic [AW-1:0]    cur_addr, b1_addr, b2_addr, nxt_addr, cur_base;
    rxw_ctrl_t        ctl;
    logic [1:0]       idx, bcnt;
    logic             buf_q, end_q, crc_q, first_pend, irq_q, cfg_q;
    logic [SZ_W-1:0]  off, off_nx, cur_size;
    logic [LEN_W-1:0] frame_len;
    logic [31:0]      word_acc, stat_w;
    logic [1:0]       bs_start;
    logic             bs_found, bs_sel, size_hit, own_ok;

    assign bs_start = (st == S_PICK) ? 2'd0 : (buf_q ? 2'd2 : 2'd1);
    assign cur_size = buf_q ? ctl.s2 : ctl.s1;
    assign cur_base = buf_q ? b2_addr : b1_addr;
    assign off_nx   = off + SZ_W'(4);
    assign size_hit = (off_nx == cur_size);
    assign own_ok   = mem_rdata[OWN_BIT];

    rxw_buf_sel u_sel (
        .s1(ctl.s1), .s2(ctl.s2), .chain(ctl.chain),
        .start(bs_start), .found(bs_found), .sel(bs_sel)
    );

    rxw_next_addr #(.AW(AW), .STRIDE(STRIDE)) u_nxt (
        .cur(cur_addr), .base(ring_base), .link(b2_addr),
        .eor(ctl.eor), .chain(ctl.chain), .nxt(nxt_addr)
    );

    always_comb begin
        stat_w            = '0;
        stat_w[FIRST_BIT] = first_pend;
        if (end_q) begin
            stat_w[LAST_BIT]                  = 1'b1;
            stat_w[CRC_BIT]                   = crc_q;
            stat_w[LEN_LSB +: LEN_W]          = frame_len;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_INIT;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_INIT:   st_nx = S_FETCH;
            S_FETCH:  st_nx = S_LATCH;
            S_LATCH:  begin
                if (idx == 2'd0 && !own_ok) st_nx = S_STALL;
                else if (idx == 2'd3)       st_nx = S_PICK;
                else                        st_nx = S_FETCH;
            end
            S_STALL:  if (poll) st_nx = S_FETCH;
            S_PICK:   st_nx = bs_found ? S_FILL : S_NEXT;
            S_FILL:   if (rx_valid && (bcnt == 2'd3 || rx_last)) st_nx = S_WRDATA;
            S_WRDATA: begin
                if (end_q)         st_nx = S_WBACK;
                else if (size_hit) st_nx = bs_found ? S_FILL : S_WBACK;
                else               st_nx = S_FILL;
            end
            S_WBACK:  st_nx = S_NEXT;
            S_NEXT:   st_nx = S_FETCH;
            default:  st_nx = S_INIT;
        endcase
    end

    // outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = cur_addr;
        mem_wdata   = '0;
        rx_ready    = 1'b0;
        buf_unavail = 1'b0;
        unique case (st)
            S_FETCH:  begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + AW'({idx, 2'b00});
            end
            S_WRDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_base + AW'(off);
                mem_wdata = word_acc;
            end
            S_WBACK:  begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_w;
            end
            S_FILL:   rx_ready    = 1'b1;
            S_STALL:  buf_unavail = 1'b1;
            default:  ;
        endcase
    end

    assign rx_irq  = irq_q;
    assign cfg_err = cfg_q;

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            b1_addr    <= '0;
            b2_addr    <= '0;
            ctl        <= '0;
            idx        <= '0;
            bcnt       <= '0;
            buf_q      <= 1'b0;
            off        <= '0;
            word_acc   <= '0;
            frame_len  <= '0;
            end_q      <= 1'b0;
            crc_q      <= 1'b0;
            first_pend <= 1'b1;
            irq_q      <= 1'b0;
            cfg_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (st)
                S_INIT:  cur_addr <= ring_base;
                S_LATCH: begin
                    if (!(idx == 2'd0 && !own_ok)) idx <= idx + 2'd1;
                    if (idx == 2'd1) begin
                        ctl   <= {mem_rdata[31], mem_rdata[15], mem_rdata[14],
                                  mem_rdata[28:16], mem_rdata[12:0]};
                        cfg_q <= (mem_rdata[1:0] != 2'b00) ||
                                 (!mem_rdata[14] && mem_rdata[17:16] != 2'b00);
                    end
                    if (idx == 2'd2) b1_addr <= mem_rdata[AW-1:0];
                    if (idx == 2'd3) b2_addr <= mem_rdata[AW-1:0];
                end
                S_PICK: begin
                    buf_q <= bs_sel;
                    off   <= '0;
                end
                S_FILL: if (rx_valid) begin
                    word_acc[8*bcnt +: 8] <= rx_data;
                    bcnt                  <= bcnt + 2'd1;
                    frame_len             <= frame_len + LEN_W'(1);
                    if (rx_last) begin
                        end_q <= 1'b1;
                        crc_q <= rx_crc_err;
                    end
                end
                S_WRDATA: begin
                    word_acc <= '0;
                    bcnt     <= '0;
                    if (size_hit && bs_found) begin
                        buf_q <= bs_sel;
                        off   <= '0;
                    end else begin
                        off <= off_nx;
                    end
                end
                S_WBACK: begin
                    first_pend <= end_q;
                    irq_q      <= end_q && !ctl.sup;
                    if (end_q) begin
                        end_q     <= 1'b0;
                        crc_q     <= 1'b0;
                        frame_len <= '0;
                    end
                end
                S_NEXT: begin
                    cur_addr <= nxt_addr;
                    idx      <= '0;
                    cfg_q    <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker
    import rxw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        poll,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        rx_ready,
    input logic        rx_irq,
    input logic        buf_unavail,
    input rxw_state_t  st
);
    p_stall_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        buf_unavail |-> !mem_req);

    p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_unavail && !poll) |=> buf_unavail);

    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !mem_req);

    p_wb_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WBACK) |-> (mem_we && !mem_wdata[OWN_BIT]));

    p_crc_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WBACK && mem_wdata[CRC_BIT]) |-> mem_wdata[LAST_BIT]);

    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(st == S_WBACK && mem_wdata[LAST_BIT]));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
endmodule

bind rx_desc_walker rxw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .poll(poll), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .rx_ready(rx_ready),
    .rx_irq(rx_irq), .buf_unavail(buf_unavail), .st(st)
);

// File: tb/sim_rx_desc_walker.sv
`timescale 1ns/1ps
module sim_rx_desc_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h0;
    logic        poll = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_last = 1'b0;
    logic        rx_crc_err = 1'b0;
    logic        rx_ready, mem_req, mem_we, rx_irq, buf_unavail, cfg_err;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;

    logic [31:0] mem     [0:1023];
    logic [31:0] exp_mem [0:1023];
    int tests = 0, fails = 0, irq_cnt = 0, cyc = 0;
    bit done = 0;

    int rs1[6], rs2[6];
    bit rch[6], rsup[6];
    int m_d, exp_irq;

    always #2.5 clk = ~clk;

    rx_desc_walker u0 (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll(poll),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_err(rx_crc_err), .rx_ready(rx_ready), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rx_irq(rx_irq), .buf_unavail(buf_unavail),
        .cfg_err(cfg_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we)  mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    end

    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    task automatic finish_all();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
            finish_all();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bv(int f, int i);
        return 8'((f * 29 + i * 7 + 3) & 255);
    endfunction

    function automatic logic [31:0] pack(int f, int i0, int n);
        logic [31:0] w = '0;
        for (int k = 0; k < n; k++) w[8*k +: 8] = bv(f, i0 + k);
        return w;
    endfunction

    function automatic logic [31:0] cw(int s1, int s2, bit ch, bit eor, bit sup);
        return (32'(sup) << 31) | (32'(s2) << 16) | (32'(eor) << 15) |
               (32'(ch) << 14) | 32'(s1);
    endfunction

    task automatic set_desc(int a, logic [31:0] s, logic [31:0] c,
                            logic [31:0] b1, logic [31:0] b2);
        mem[a/4] = s; mem[a/4+1] = c; mem[a/4+2] = b1; mem[a/4+3] = b2;
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 1024; k++) mem[k] = '0;
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(int f, int len, bit crc);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid   = 1'b1;
            rx_data    = bv(f, i);
            rx_last    = (i == len - 1);
            rx_crc_err = crc && (i == len - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0;
    endtask

    // transaction-level model of the requirements for the random ring
    task automatic model_frame(int f, int len, bit crc, bit doit, output bit ok);
        int d = m_d, i = 0, sz, ba;
        bit first = 1, last;
        ok = 1;
        while (i < len) begin
            if (d >= 6) begin ok = 0; return; end
            if (rs1[d] == 0 && (rch[d] || rs2[d] == 0)) begin d++; continue; end
            for (int b = 0; b < 2; b++) begin
                sz = (b == 0) ? rs1[d] : (rch[d] ? 0 : rs2[d]);
                ba = 32'h400 + d * 32'h80 + b * 32'h40;
                for (int o = 0; o < sz && i < len; o++) begin
                    if (doit) exp_mem[(ba + o) / 4][8*((ba + o) % 4) +: 8] = bv(f, i);
                    i++;
                end
            end
            last = (i == len);
            if (doit) begin
                exp_mem[d*4] = (32'(first) << 9) |
                    (last ? ((32'(len) << 16) | 32'h100 | (32'(crc) << 1)) : 32'h0);
                if (last && !rsup[d]) exp_irq++;
            end
            first = 0;
            d++;
        end
        if (doit) m_d = d;
    endtask

    initial begin
        int r, base_irq, bad;
        bit ok;
        r = $urandom(32'd4242);

        // ---------------- directed ring ----------------
        clear_mem();
        set_desc(32'h000, 32'h8000_0000, cw(8, 4, 0, 0, 0), 32'h400, 32'h440);
        set_desc(32'h010, 32'h8000_0000, cw(0, 8, 0, 0, 0), 32'h480, 32'h4C0);
        set_desc(32'h020, 32'h8000_0000, cw(4, 12, 1, 0, 0), 32'h500, 32'h200);
        set_desc(32'h200, 32'h8000_0000, cw(16, 0, 1, 1, 1), 32'h540, 32'h300);
        set_desc(32'h300, 32'h8000_0000, cw(16, 0, 0, 0, 0), 32'h600, 32'h0);
        ticks(3);
        chk("R10 mem_req in reset", 32'(mem_req), 0);
        chk("R10 rx_ready in reset", 32'(rx_ready), 0);
        chk("R10 rx_irq in reset", 32'(rx_irq), 0);
        chk("R10 buf_unavail in reset", 32'(buf_unavail), 0);
        chk("R10 cfg_err in reset", 32'(cfg_err), 0);
        rst_n = 1'b1;
        base_irq = irq_cnt;

        send_frame(1, 10, 0);
        send_frame(2, 12, 1);
        send_frame(3, 5, 0);
        ticks(40);
        chk("R7 desc0 status first+last len10", mem[0], 32'h000A_0300);
        chk("R2 buf1 word0", mem[32'h400/4], pack(1, 0, 4));
        chk("R2 buf1 word1", mem[32'h404/4], pack(1, 4, 4));
        chk("R2 buf2 partial word", mem[32'h440/4], pack(1, 8, 2));
        chk("R3 skipped buf1 untouched", mem[32'h480/4], 0);
        chk("R6 desc1 status first only", mem[32'h10/4], 32'h0000_0200);
        chk("R3 buf2 used after zero buf1", mem[32'h4C4/4], pack(2, 4, 4));
        chk("R7 crc on last desc only", mem[32'h20/4], 32'h000C_0102);
        chk("R11 frame2 tail in desc2", mem[32'h500/4], pack(2, 8, 4));
        chk("R4 chained buf2 field ignored", mem[32'h200/4 + 0], 32'h0005_0300);
        chk("R4 chained desc3 data", mem[32'h544/4], pack(3, 4, 1));
        chk("R8 irq count, suppressed on desc3", 32'(irq_cnt - base_irq), 2);
        chk("R5 stall at base, not chain link", 32'(buf_unavail), 1);
        chk("R5 chain link desc untouched", mem[32'h300/4], 32'h8000_0000);
        chk("R9 no cfg_err on valid sizes", 32'(cfg_err), 0);

        mem[0] = 32'h8000_0000;
        ticks(5);
        chk("R1 stall holds without poll", 32'(buf_unavail), 1);
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
        send_frame(4, 3, 0);
        ticks(30);
        chk("R1 resumed after poll", mem[0], 32'h0003_0300);
        chk("R2 resumed data", mem[32'h400/4], pack(4, 0, 3));
        chk("R8 irq after resume", 32'(irq_cnt - base_irq), 3);

        // ---------------- size error ----------------
        @(negedge clk); rst_n = 1'b0;
        clear_mem();
        set_desc(32'h000, 32'h8000_0000, cw(6, 0, 0, 0, 0), 32'h400, 32'h0);
        ticks(3); rst_n = 1'b1;
        ticks(20);
        chk("R9 cfg_err on size 6", 32'(cfg_err), 1);

        // ---------------- random ring ----------------
        @(negedge clk); rst_n = 1'b0;
        clear_mem();
        for (int k = 0; k < 6; k++) begin
            rs1[k]  = 4 * ($urandom % 5);
            rs2[k]  = 4 * ($urandom % 5);
            rch[k]  = ($urandom % 4) == 0;
            rsup[k] = ($urandom % 4) == 0;
            set_desc(k * 16, 32'h8000_0000, cw(rs1[k], rs2[k], rch[k], k == 5, rsup[k]),
                     32'h400 + k * 32'h80, rch[k] ? ((k == 5) ? 32'h300 : (k + 1) * 16)
                                                  : 32'h440 + k * 32'h80);
        end
        for (int k = 0; k < 1024; k++) exp_mem[k] = mem[k];
        m_d = 0; exp_irq = 0;
        ticks(3); rst_n = 1'b1;
        base_irq = irq_cnt;
        for (int f = 0; f < 20; f++) begin
            int len;
            bit crc;
            len = 1 + ($urandom % 10);
            crc = $urandom % 2;
            model_frame(f + 10, len, crc, 0, ok);
            if (!ok) break;
            model_frame(f + 10, len, crc, 1, ok);
            send_frame(f + 10, len, crc);
        end
        ticks(60);
        for (int k = 0; k < 6; k++)
            chk($sformatf("R7 random desc%0d status", k), mem[k*4], exp_mem[k*4]);
        bad = 0;
        for (int k = 256; k < 512; k++) if (mem[k] !== exp_mem[k]) bad++;
        chk("R2 random buffer words mismatched", 32'(bad), 0);
        chk("R8 random irq count", 32'(irq_cnt - base_irq), 32'(exp_irq));

        done = 1;
        finish_all();
    end
endmodule